// File: doc/BRIEF.md
# Fetch Response Instruction Unpacker

This block sits between the instruction memory's response path and the per-wavefront instruction buffers of a compute unit. A fetch response carries the tag of the wavefront that asked for it, a byte count and a payload of 32-bit words. The block walks the payload one instruction per cycle and hands each instruction to the buffer write port as a single 64-bit entry. Instructions come in two lengths, chosen by the top bit of their first word. A long instruction uses two payload words but still fills only one buffer entry.

Each wavefront has a pending flag and a drop flag, both kept in the block. A fetch issue sets the pending flag. A cancel that arrives while a fetch is outstanding sets the drop flag. When the response for a dropped fetch comes back, it is thrown away without being unpacked. Every response that has been fully handled clears both flags of its wavefront. Every entry that is pushed is stamped with a global sequence number, which then advances by one.

Top module: `fetch_unpacker`

## Requirements
- R1: The payload holds `rsp_bytes / 4` words, so the two low bits of `rsp_bytes` are ignored.
- R2: A word whose bit 31 is 0 is a short instruction. It is pushed as one entry with the word in bits 31:0 and zeros in bits 63:32, and the walk moves on by one word.
- R3: A word whose bit 31 is 1 starts a long instruction. That word and the next one are pushed as one entry, the first word in bits 31:0 and the second in bits 63:32, and the walk moves on by two words.
- R4: The first entry appears in the cycle after the response is accepted, and one entry or error follows in each cycle after that until the payload is used up. After that `push_valid` is low.
- R5: `rsp_ready` is high whenever the block is idle and low while a payload is being walked.
- R6: The sequence number is 0 after reset. Each pushed entry carries the current value, which then goes up by 1. Dropped, empty and faulty parts push nothing and do not advance it.
- R7: A cancel for a pending wavefront sets its `drop_pending` bit. A response for that wavefront is then accepted and discarded: nothing is pushed, and both its drop and pending bits are cleared at the accepting edge.
- R8: A fetch issue sets the wavefront's `pending` bit from the next cycle on. The bit clears at the clock edge that ends the handling of that wavefront's response.
- R9: A long instruction whose second word would lie past the payload end is not pushed. `unpack_err` is high for one cycle in its place, and the response ends there.
- R10: A response with fewer than 4 bytes is accepted, pushes nothing and clears the pending bit at the accepting edge.
- R11: After reset, all pending and drop bits are 0, `rsp_ready` is 1, and `push_valid` and `unpack_err` are 0.
- R12: A cancel for a wavefront with no pending fetch is ignored, and its drop bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A fetch is issued for `issue_wave` |
| issue_wave | input | WAVE_W | Wavefront of the issued fetch |
| cancel_valid | input | 1 | Cancel the outstanding fetch of `cancel_wave` |
| cancel_wave | input | WAVE_W | Wavefront whose fetch is cancelled |
| rsp_valid | input | 1 | A fetch response is offered |
| rsp_ready | output | 1 | The block can accept a response |
| rsp_wave | input | WAVE_W | Wavefront tag of the response |
| rsp_bytes | input | BYTE_W | Byte count of the response |
| rsp_data | input | MAX_WORDS*32 | Payload, word i in bits 32i+31:32i |
| push_valid | output | 1 | An instruction entry is written this cycle |
| push_wave | output | WAVE_W | Target wavefront buffer |
| push_inst | output | 64 | Instruction entry |
| push_seq | output | SEQ_W | Sequence number of the entry |
| unpack_err | output | 1 | A long instruction was cut off by the end of the payload |
| pending | output | NUM_WAVES | Per-wavefront fetch-outstanding bits |
| drop_pending | output | NUM_WAVES | Per-wavefront discard-on-return bits |

## Verification
On every cycle, the assertions check the following: the sequence counter advances only with a push, a short entry has a zero upper half, the walk continues without gaps until its last step, `rsp_ready` comes back after the last step, and a finished wavefront has both flags cleared at the next edge. Some behaviour can only be seen from the bench's scenarios. These are the exact bit packing of long instructions, where a payload gets cut off, how the byte count is rounded, the discard of cancelled fetches and the ignoring of stray cancels. To cover them, the bench sweeps every pattern of short and long lead words across every payload length and compares each pushed entry against its own walk of the payload.

// File: rtl/fru_pkg.sv
package fru_pkg;

    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 64;
    localparam int LEN_BIT = 31;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic {
        WALK_IDLE   = 1'b0,
        WALK_ACTIVE = 1'b1
    } walk_state_e;

    function automatic logic is_long(input word_t w);
        return w[LEN_BIT];
    endfunction

    function automatic entry_t build_entry(input word_t lo, input word_t hi, input logic long_i);
        return long_i ? {hi, lo} : {{WORD_W{1'b0}}, lo};
    endfunction

endpackage

// File: rtl/fru_seq_counter.sv
module fru_seq_counter #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [SEQ_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (bump) begin
            value <= value + SEQ_W'(1);
        end
    end
endmodule

// File: rtl/fru_wave_flags.sv
module fru_wave_flags #(
    parameter int NUM_WAVES = 4,
    parameter int WAVE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_valid,
    input  logic [WAVE_W-1:0]    issue_wave,
    input  logic                 cancel_valid,
    input  logic [WAVE_W-1:0]    cancel_wave,
    input  logic                 fin_valid,
    input  logic [WAVE_W-1:0]    fin_wave,
    input  logic [WAVE_W-1:0]    sel_wave,
    output logic                 sel_drop,
    output logic [NUM_WAVES-1:0] pend_q,
    output logic [NUM_WAVES-1:0] drop_q
);
    for (genvar g = 0; g < NUM_WAVES; g++) begin : g_wave
        logic set_pend, set_drop, clr_both;
        assign set_pend = issue_valid  && (issue_wave  == WAVE_W'(g));
        assign set_drop = cancel_valid && (cancel_wave == WAVE_W'(g)) && pend_q[g];
        assign clr_both = fin_valid    && (fin_wave    == WAVE_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
                drop_q[g] <= 1'b0;
            end else begin
                pend_q[g] <= (pend_q[g] || set_pend) && !clr_both;
                drop_q[g] <= (drop_q[g] || set_drop) && !clr_both;
            end
        end
    end

    always_comb begin
        sel_drop = 1'b0;
        for (int i = 0; i < NUM_WAVES; i++) begin
            if (sel_wave == WAVE_W'(i)) sel_drop = drop_q[i];
        end
    end

    // R7, R8: a finished wavefront has both flags clear after the edge
    assert_fin_clears_pend_R8: assert property (@(posedge clk) disable iff (rst)
        fin_valid |=> !pend_q[$past(fin_wave)]);
    assert_fin_clears_drop_R7: assert property (@(posedge clk) disable iff (rst)
        fin_valid |=> !drop_q[$past(fin_wave)]);
    // R12: a drop bit never rises without a pending fetch
    assert_drop_needs_pend_R12: assert property (@(posedge clk) disable iff (rst)
        (cancel_valid && !pend_q[cancel_wave] && !drop_q[cancel_wave]) |=> !drop_q[$past(cancel_wave)]);
endmodule

// File: rtl/fru_walker.sv
module fru_walker
    import fru_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    parameter int WAVE_W    = 2,
    parameter int BYTE_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rsp_valid,
    output logic                        rsp_ready,
    input  logic [WAVE_W-1:0]           rsp_wave,
    input  logic [BYTE_W-1:0]           rsp_bytes,
    input  logic [MAX_WORDS*WORD_W-1:0] rsp_data,
    input  logic                        drop_sel,
    output logic                        emit_valid,
    output logic                        emit_err,
    output logic [WAVE_W-1:0]           emit_wave,
    output entry_t                      emit_inst,
    output logic                        fin_valid,
    output logic [WAVE_W-1:0]           fin_wave
);
    localparam int IDX_W = $clog2(MAX_WORDS + 2);

    walk_state_e       state_q;
    logic [WAVE_W-1:0] wave_q;
    word_t             words_q [MAX_WORDS];
    logic [IDX_W-1:0]  nw_q;
    logic [IDX_W-1:0]  idx_q;

    logic             busy, accept, skip_in, long_w, has_pair, last;
    logic [IDX_W-1:0] nw_in, idx_nx1, idx_next;
    word_t            first_w, second_w;

    assign busy      = (state_q == WALK_ACTIVE);
    assign rsp_ready = !busy;
    assign accept    = rsp_valid && rsp_ready;
    assign nw_in     = IDX_W'(rsp_bytes >> 2);
    assign skip_in   = drop_sel || (nw_in == '0);
    assign idx_nx1   = idx_q + IDX_W'(1);

    always_comb begin
        first_w  = '0;
        second_w = '0;
        for (int i = 0; i < MAX_WORDS; i++) begin
            if (idx_q   == IDX_W'(i)) first_w  = words_q[i];
            if (idx_nx1 == IDX_W'(i)) second_w = words_q[i];
        end
    end

    assign long_w     = is_long(first_w);
    assign has_pair   = (idx_nx1 < nw_q);
    assign emit_err   = busy && long_w && !has_pair;
    assign emit_valid = busy && !emit_err;
    assign emit_wave  = wave_q;
    assign emit_inst  = build_entry(first_w, second_w, long_w);
    assign idx_next   = idx_q + (long_w ? IDX_W'(2) : IDX_W'(1));
    assign last       = busy && (idx_next >= nw_q);
    assign fin_valid  = last || (accept && skip_in);
    assign fin_wave   = busy ? wave_q : rsp_wave;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            wave_q  <= '0;
            nw_q    <= '0;
            idx_q   <= '0;
            for (int i = 0; i < MAX_WORDS; i++) words_q[i] <= '0;
        end else if (busy) begin
            if (last) begin
                state_q <= WALK_IDLE;
            end else begin
                idx_q <= idx_next;
            end
        end else if (accept && !skip_in) begin
            state_q <= WALK_ACTIVE;
            wave_q  <= rsp_wave;
            nw_q    <= nw_in;
            idx_q   <= '0;
            for (int i = 0; i < MAX_WORDS; i++) words_q[i] <= rsp_data[i*WORD_W +: WORD_W];
        end
    end

    // R2: short entries carry a zero upper half
    assert_short_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (emit_valid && !emit_inst[LEN_BIT]) |-> (emit_inst[ENTRY_W-1:WORD_W] == '0));
    // R4: a kept, non-empty response starts producing in the next cycle
    assert_first_step_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !skip_in) |=> (emit_valid || emit_err));
    // R4: no gap until the last step
    assert_no_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (emit_valid || emit_err));
    // R5: ready returns right after the last step
    assert_ready_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        last |=> rsp_ready);
    // R9: an error ends the walk
    assert_err_ends_R9: assert property (@(posedge clk) disable iff (rst)
        emit_err |=> (!emit_valid && !emit_err));
endmodule

// File: rtl/fetch_unpacker.sv
module fetch_unpacker
    import fru_pkg::*;
#(
    parameter int NUM_WAVES = 4,
    parameter int MAX_WORDS = 8,
    parameter int SEQ_W     = 16,
    localparam int WAVE_W   = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
    localparam int BYTE_W   = $clog2(MAX_WORDS*4 + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        issue_valid,
    input  logic [WAVE_W-1:0]           issue_wave,
    input  logic                        cancel_valid,
    input  logic [WAVE_W-1:0]           cancel_wave,
    input  logic                        rsp_valid,
    output logic                        rsp_ready,
    input  logic [WAVE_W-1:0]           rsp_wave,
    input  logic [BYTE_W-1:0]           rsp_bytes,
    input  logic [MAX_WORDS*WORD_W-1:0] rsp_data,
    output logic                        push_valid,
    output logic [WAVE_W-1:0]           push_wave,
    output logic [ENTRY_W-1:0]          push_inst,
    output logic [SEQ_W-1:0]            push_seq,
    output logic                        unpack_err,
    output logic [NUM_WAVES-1:0]        pending,
    output logic [NUM_WAVES-1:0]        drop_pending
);
    logic              sel_drop, fin_valid;
    logic [WAVE_W-1:0] fin_wave;

    fru_wave_flags #(.NUM_WAVES(NUM_WAVES), .WAVE_W(WAVE_W)) flags_i (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_wave(issue_wave),
        .cancel_valid(cancel_valid), .cancel_wave(cancel_wave),
        .fin_valid(fin_valid), .fin_wave(fin_wave),
        .sel_wave(rsp_wave), .sel_drop(sel_drop),
        .pend_q(pending), .drop_q(drop_pending)
    );

    fru_walker #(.MAX_WORDS(MAX_WORDS), .WAVE_W(WAVE_W), .BYTE_W(BYTE_W)) walker_i (
        .clk(clk), .rst(rst),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_wave(rsp_wave), .rsp_bytes(rsp_bytes), .rsp_data(rsp_data),
        .drop_sel(sel_drop),
        .emit_valid(push_valid), .emit_err(unpack_err),
        .emit_wave(push_wave), .emit_inst(push_inst),
        .fin_valid(fin_valid), .fin_wave(fin_wave)
    );

    fru_seq_counter #(.SEQ_W(SEQ_W)) seq_i (
        .clk(clk), .rst(rst), .bump(push_valid), .value(push_seq)
    );

    // R6: the stamp advances by one per push and holds otherwise
    assert_seq_step_R6: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> (push_seq == $past(push_seq) + SEQ_W'(1)));
    assert_seq_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !push_valid |=> $stable(push_seq));
    // R7: a dropped response pushes nothing in the following cycle
    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && drop_pending[rsp_wave]) |=> (!push_valid && !unpack_err));
endmodule

// File: tb/fetch_unpacker_tb_top.sv
module fetch_unpacker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int MW = 8;
    localparam int SW = 16;
    localparam int WW = 2;
    localparam int BW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue_valid = 1'b0, cancel_valid = 1'b0, rsp_valid = 1'b0;
    logic [WW-1:0] issue_wave = '0, cancel_wave = '0, rsp_wave = '0;
    logic [BW-1:0] rsp_bytes = '0;
    logic [MW*32-1:0] rsp_data = '0;
    logic rsp_ready, push_valid, unpack_err;
    logic [WW-1:0] push_wave;
    logic [63:0] push_inst;
    logic [SW-1:0] push_seq;
    logic [NW-1:0] pending, drop_pending;

    fetch_unpacker #(.NUM_WAVES(NW), .MAX_WORDS(MW), .SEQ_W(SW)) dut_i (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_wave(issue_wave),
        .cancel_valid(cancel_valid), .cancel_wave(cancel_wave),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_wave(rsp_wave), .rsp_bytes(rsp_bytes), .rsp_data(rsp_data),
        .push_valid(push_valid), .push_wave(push_wave), .push_inst(push_inst),
        .push_seq(push_seq), .unpack_err(unpack_err),
        .pending(pending), .drop_pending(drop_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int exp_seq = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input int wave);
        issue_valid = 1'b1;
        issue_wave  = WW'(wave);
        @(negedge clk);
        issue_valid = 1'b0;
        check(pending[wave] == 1'b1, "R8 pending set", 64'(pending[wave]), 64'd1);
    endtask

    task automatic do_rsp(input int wave, input int nbytes, input logic [31:0] w [MW], input bit dropped);
        logic [63:0] ev [MW];
        bit eerr [MW];
        int ne = 0;
        int n = nbytes / 4;
        if (!dropped) begin
            int idx = 0;
            while (idx < n) begin
                if (w[idx][31]) begin
                    if (idx + 1 < n) begin ev[ne] = {w[idx+1], w[idx]}; eerr[ne] = 1'b0; end
                    else begin ev[ne] = '0; eerr[ne] = 1'b1; end
                    idx += 2;
                end else begin
                    ev[ne] = {32'd0, w[idx]}; eerr[ne] = 1'b0;
                    idx += 1;
                end
                ne++;
            end
        end
        check(rsp_ready == 1'b1, "R5 ready when idle", 64'(rsp_ready), 64'd1);
        rsp_valid = 1'b1;
        rsp_wave  = WW'(wave);
        rsp_bytes = BW'(nbytes);
        for (int i = 0; i < MW; i++) rsp_data[i*32 +: 32] = w[i];
        @(negedge clk);
        rsp_valid = 1'b0;
        for (int k = 0; k < ne; k++) begin
            check(rsp_ready == 1'b0, "R5 not ready while walking", 64'(rsp_ready), 64'd0);
            if (eerr[k]) begin
                check(unpack_err && !push_valid, "R9 truncated long", {62'd0, unpack_err, push_valid}, 64'd2);
            end else begin
                check(push_valid && !unpack_err, "R4 one entry per cycle", {62'd0, unpack_err, push_valid}, 64'd1);
                if (ev[k][31]) check(push_inst == ev[k], "R3 long entry", push_inst, ev[k]);
                else           check(push_inst == ev[k], "R2 short entry", push_inst, ev[k]);
                check(push_wave == WW'(wave), "R4 target wave", 64'(push_wave), 64'(wave));
                check(push_seq == SW'(exp_seq), "R6 sequence stamp", 64'(push_seq), 64'(exp_seq));
                exp_seq++;
            end
            @(negedge clk);
        end
        check(!push_valid && !unpack_err, "R4 quiet after end", {62'd0, unpack_err, push_valid}, 64'd0);
        check(rsp_ready == 1'b1, "R5 ready after end", 64'(rsp_ready), 64'd1);
        if (n == 0) check(pending[wave] == 1'b0, "R10 empty clears pending", 64'(pending[wave]), 64'd0);
        else        check(pending[wave] == 1'b0, "R8 pending cleared", 64'(pending[wave]), 64'd0);
        check(drop_pending[wave] == 1'b0, "R7 drop clear after response", 64'(drop_pending[wave]), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] w [MW];
        int cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check(pending == '0 && drop_pending == '0, "R11 flags reset", {56'd0, pending, drop_pending}, 64'd0);
        check(rsp_ready && !push_valid && !unpack_err, "R11 outputs reset",
              {61'd0, rsp_ready, push_valid, unpack_err}, 64'd4);
        check(push_seq == '0, "R6 seq reset", 64'(push_seq), 64'd0);

        // Sweep every lead-bit pattern for every payload length (R1 via low byte bits)
        for (int n = 0; n <= MW; n++) begin
            for (int m = 0; m < (1 << n); m++) begin
                int wave = cnt % NW;
                for (int i = 0; i < MW; i++)
                    w[i] = {(i < n) ? m[i] : 1'b0, 31'(n*100000 + m*64 + i + 1)};
                issue(wave);
                do_rsp(wave, n*4 + (cnt % 4), w, 1'b0);
                cnt++;
            end
        end

        // R7: cancel while pending, response discarded
        issue(2);
        cancel_valid = 1'b1; cancel_wave = 2'd2;
        @(negedge clk);
        cancel_valid = 1'b0;
        check(drop_pending[2] == 1'b1, "R7 drop set", 64'(drop_pending[2]), 64'd1);
        for (int i = 0; i < MW; i++) w[i] = 32'h0000_1000 + 32'(i);
        do_rsp(2, 16, w, 1'b1);
        check(push_seq == SW'(exp_seq), "R6 seq held over drop", 64'(push_seq), 64'(exp_seq));
        issue(2);
        do_rsp(2, 12, w, 1'b0);

        // R12: stray cancel ignored
        cancel_valid = 1'b1; cancel_wave = 2'd1;
        @(negedge clk);
        cancel_valid = 1'b0;
        check(drop_pending[1] == 1'b0, "R12 stray cancel ignored", 64'(drop_pending[1]), 64'd0);
        issue(1);
        w[0] = 32'h8000_00AA; w[1] = 32'h1234_5678; w[2] = 32'h0000_0055;
        do_rsp(1, 12, w, 1'b0);

        // R1: byte count 7 carries one word only
        issue(3);
        w[0] = 32'h0000_0777; w[1] = 32'h0000_0888;
        do_rsp(3, 7, w, 1'b0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule